// File: doc/BRIEF.md
# Stop-Mode Clock Resource and Wakeup Controller

This controller decides which clock resources keep running while the chip sits in its low-power stop state, and when the system clocks return after a wakeup request. Software picks one of four stop codes and sets or clears a fast-wakeup bit in a small control register. A stop request gates the system clocks and loads registered enables for the PLL, the oscillator and the clock-output pin from the chosen code. A wakeup request turns every resource back on and brings back the system clocks. Depending on the fast-wakeup bit, this happens at once or only after the PLL reports lock.

When fast wakeup is clear and an enabled clock source failed during stop, the controller does not wait for lock. It resumes at once in a fallback mode. A lost oscillator gives the self-clocked mode and a lost PLL clock gives the reference-clock mode. When the clock-mode straps select external clocking, the wakeup is always immediate.

A read-only status word reports the straps, the current and sticky lock state and a loss-of-clock flag. The lock and loss inputs are asynchronous and pass through a two-flop synchronizer before any use. All pins are plain level control and status. The block has no streaming data path.

Top module: `clkpwr_stop_ctrl`

## Requirements
- R1: While the controller is stopped or waiting for lock, `sysclk_en` is 0 for every stop code; it drops one clock after `stop_req` is sampled high in run.
- R2: On stop entry the enables {`pll_en`,`osc_en`,`clkout_en`} take the stop code (control bits 1:0) as follows: 00 gives 111, 01 gives 110, 10 gives 010 and 11 gives 000.
- R3: With control bit 2 (fast wakeup) set, `sysclk_en` returns one clock after `wake_req` is sampled in stop, whatever the lock state.
- R4: With fast wakeup clear in PLL mode and no loss, `sysclk_en` returns one clock after the synchronized lock is seen high, and stays 0 while lock is low.
- R5: With fast wakeup clear, an oscillator loss (while `osc_en` is 1) during stop makes wakeup immediate with `fallback_mode` = 01. A PLL clock loss (while `pll_en` is 1) gives 10, and the oscillator loss wins if both occur. A loss on a disabled resource is ignored. `fallback_mode` returns to 00 at the next stop entry.
- R6: With `strap_pll_mode` = 0 (external clock), wakeup is immediate regardless of fast wakeup and lock.
- R7: The status word (address 1) is {`strap_pll_mode`, `strap_pll_sel`, `strap_pll_ref`, sticky lock-lost, synchronized lock, synchronized loss of either clock, 2'b00}, from bit 7 down to bit 0.
- R8: A write to address 1 changes neither register and completes without error. The control word (address 0) reads back {5'b0, fast wakeup, stop code}, and its upper bits are dropped on write.
- R9: Sticky lock-lost sets when synchronized lock falls after having once been high, and clears only on reset.
- R10: A change on `pll_lock_in` shows in status bit 3 after exactly two rising edges.
- R11: While stopped, a control write does not change the resource enables.
- R12: After reset all four enables are 1, `fallback_mode` is 00 and the control word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects control, 1 selects status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| stop_req | input | 1 | Stop-entry request, sampled in run |
| wake_req | input | 1 | Wakeup request, sampled in stop |
| pll_lock_in | input | 1 | Asynchronous PLL lock indication |
| loss_ref_in | input | 1 | Asynchronous oscillator/reference loss |
| loss_pll_in | input | 1 | Asynchronous PLL output clock loss |
| strap_pll_mode | input | 1 | 1 = PLL clocking, 0 = external clock |
| strap_pll_sel | input | 1 | PLL select strap, reported in status |
| strap_pll_ref | input | 1 | PLL reference strap, reported in status |
| sysclk_en | output | 1 | System clock enable |
| pll_en | output | 1 | PLL enable |
| osc_en | output | 1 | Oscillator enable |
| clkout_en | output | 1 | Clock-output pin enable |
| fallback_mode | output | 2 | 00 normal, 01 self-clocked, 10 reference-clock |

## Verification
A table sweeps all four stop codes, each with fast wakeup set and clear and with lock held high. This separates the enable decode for each code and the one-cycle gap between fast and lock-gated wakeup. Directed cases then drop lock during stop to show that the wakeup waits and that the sticky flag keeps its value after relock. They inject oscillator and PLL losses on enabled and on disabled resources to tell the two fallback codes apart from the ignored case. Another case switches to external clocking with lock low, and others write while stopped and write the status address.

// File: rtl/clkpwr_pkg.sv
package clkpwr_pkg;
  localparam int REG_W   = 8;
  localparam int SEL_W   = 2;
  localparam int CTRL_W  = SEL_W + 1;
  localparam int SYNC_N  = 2;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STOP = 2'd1,
    ST_WAIT = 2'd2
  } wake_st_e;

  typedef enum logic [1:0] {
    FB_NONE = 2'b00,
    FB_SELF = 2'b01,
    FB_REF  = 2'b10
  } fallback_e;

  typedef struct packed {
    logic pll;
    logic osc;
    logic clkout;
  } keep_t;

  // Resources left running for each stop code.
  function automatic keep_t keep_decode(input logic [SEL_W-1:0] code);
    keep_t k;
    case (code)
      2'b00:   k = '{pll: 1'b1, osc: 1'b1, clkout: 1'b1};
      2'b01:   k = '{pll: 1'b1, osc: 1'b1, clkout: 1'b0};
      2'b10:   k = '{pll: 1'b0, osc: 1'b1, clkout: 1'b0};
      default: k = '{pll: 1'b0, osc: 1'b0, clkout: 1'b0};
    endcase
    return k;
  endfunction
endpackage

// File: rtl/clkpwr_sync.sv
module clkpwr_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/clkpwr_regs.sv
module clkpwr_regs
  import clkpwr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             strap_mode,
  input  logic             strap_sel,
  input  logic             strap_ref,
  input  logic             lock_s,
  input  logic             loss_any_s,
  output logic [SEL_W-1:0] stop_sel,
  output logic             fast_wake
);
  localparam int PAD_W = REG_W - CTRL_W;

  logic [CTRL_W-1:0] ctrl_q;
  logic              seen_q;
  logic              lost_q;
  logic [REG_W-1:0]  status_w;
  logic [PAD_W-1:0]  unused_hi;

  assign unused_hi = reg_wdata[REG_W-1:CTRL_W];

  // Only address 0 is writable; address 1 accepts and discards.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (reg_we && !reg_addr) ctrl_q <= reg_wdata[CTRL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      if (lock_s) seen_q <= 1'b1;
      if (seen_q && !lock_s) lost_q <= 1'b1;
    end
  end

  assign status_w  = {strap_mode, strap_sel, strap_ref, lost_q, lock_s, loss_any_s, 2'b00};
  assign reg_rdata = reg_addr ? status_w : {{PAD_W{1'b0}}, ctrl_q};
  assign stop_sel  = ctrl_q[SEL_W-1:0];
  assign fast_wake = ctrl_q[SEL_W];

  assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lost_q |=> lost_q);
  assert_sticky_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost_q) |-> $past(seen_q));
  assert_status_write_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr) |=> $stable(ctrl_q));
endmodule

// File: rtl/clkpwr_wake_fsm.sv
module clkpwr_wake_fsm
  import clkpwr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_req,
  input  logic             wake_req,
  input  logic [SEL_W-1:0] stop_sel,
  input  logic             fast_wake,
  input  logic             pll_mode,
  input  logic             lock_s,
  input  logic             loss_ref_s,
  input  logic             loss_pll_s,
  output logic             sysclk_en,
  output logic             pll_en,
  output logic             osc_en,
  output logic             clkout_en,
  output logic [1:0]       fallback_mode
);
  wake_st_e  st_q;
  keep_t     keep_q;
  logic      sys_q;
  fallback_e fb_q;
  logic      osc_lost_q, pll_lost_q;
  logic      osc_gone, pll_gone;

  // A loss counts only on a resource left running during stop.
  assign osc_gone = osc_lost_q | (loss_ref_s & keep_q.osc);
  assign pll_gone = pll_lost_q | (loss_pll_s & keep_q.pll);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_RUN;
      keep_q     <= '{pll: 1'b1, osc: 1'b1, clkout: 1'b1};
      sys_q      <= 1'b1;
      fb_q       <= FB_NONE;
      osc_lost_q <= 1'b0;
      pll_lost_q <= 1'b0;
    end else begin
      case (st_q)
        ST_RUN: begin
          if (stop_req) begin
            st_q       <= ST_STOP;
            sys_q      <= 1'b0;
            keep_q     <= keep_decode(stop_sel);
            fb_q       <= FB_NONE;
            osc_lost_q <= 1'b0;
            pll_lost_q <= 1'b0;
          end
        end
        ST_STOP: begin
          osc_lost_q <= osc_gone;
          pll_lost_q <= pll_gone;
          if (wake_req) begin
            keep_q <= '{pll: 1'b1, osc: 1'b1, clkout: 1'b1};
            if (!pll_mode || fast_wake) begin
              st_q  <= ST_RUN;
              sys_q <= 1'b1;
            end else if (osc_gone) begin
              st_q  <= ST_RUN;
              sys_q <= 1'b1;
              fb_q  <= FB_SELF;
            end else if (pll_gone) begin
              st_q  <= ST_RUN;
              sys_q <= 1'b1;
              fb_q  <= FB_REF;
            end else begin
              st_q  <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (lock_s) begin
            st_q  <= ST_RUN;
            sys_q <= 1'b1;
          end
        end
        default: st_q <= ST_RUN;
      endcase
    end
  end

  assign sysclk_en     = sys_q;
  assign pll_en        = keep_q.pll;
  assign osc_en        = keep_q.osc;
  assign clkout_en     = keep_q.clkout;
  assign fallback_mode = fb_q;

  assert_stop_gates_sysclk_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_RUN) |-> !sysclk_en);
  assert_pll_needs_osc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STOP && pll_en) |-> osc_en);
  assert_fast_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STOP && wake_req && fast_wake) |=> (sysclk_en && fallback_mode == FB_NONE));
  assert_lock_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && !lock_s) |=> !sysclk_en);
  assert_fallback_one_hot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fallback_mode));
  assert_ext_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STOP && wake_req && !pll_mode) |=> sysclk_en);
  assert_keep_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STOP && !wake_req) |=> $stable(keep_q));
endmodule

// File: rtl/clkpwr_stop_ctrl.sv
module clkpwr_stop_ctrl
  import clkpwr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             stop_req,
  input  logic             wake_req,
  input  logic             pll_lock_in,
  input  logic             loss_ref_in,
  input  logic             loss_pll_in,
  input  logic             strap_pll_mode,
  input  logic             strap_pll_sel,
  input  logic             strap_pll_ref,
  output logic             sysclk_en,
  output logic             pll_en,
  output logic             osc_en,
  output logic             clkout_en,
  output logic [1:0]       fallback_mode
);
  logic [2:0]       sync_q;
  logic [SEL_W-1:0] stop_sel;
  logic             fast_wake;

  clkpwr_sync #(.WIDTH(3), .STAGES(SYNC_N)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({pll_lock_in, loss_ref_in, loss_pll_in}),
    .q     (sync_q)
  );

  clkpwr_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .strap_mode (strap_pll_mode),
    .strap_sel  (strap_pll_sel),
    .strap_ref  (strap_pll_ref),
    .lock_s     (sync_q[2]),
    .loss_any_s (sync_q[1] | sync_q[0]),
    .stop_sel   (stop_sel),
    .fast_wake  (fast_wake)
  );

  clkpwr_wake_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .stop_req      (stop_req),
    .wake_req      (wake_req),
    .stop_sel      (stop_sel),
    .fast_wake     (fast_wake),
    .pll_mode      (strap_pll_mode),
    .lock_s        (sync_q[2]),
    .loss_ref_s    (sync_q[1]),
    .loss_pll_s    (sync_q[0]),
    .sysclk_en     (sysclk_en),
    .pll_en        (pll_en),
    .osc_en        (osc_en),
    .clkout_en     (clkout_en),
    .fallback_mode (fallback_mode)
  );
endmodule

// File: tb/sim_clkpwr_stop_ctrl.sv
`timescale 1ns/1ps
module sim_clkpwr_stop_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  logic       stop_req = 1'b0, wake_req = 1'b0;
  logic       pll_lock_in = 1'b0, loss_ref_in = 1'b0, loss_pll_in = 1'b0;
  logic       strap_pll_mode = 1'b1, strap_pll_sel = 1'b0, strap_pll_ref = 1'b1;
  logic       sysclk_en, pll_en, osc_en, clkout_en;
  logic [1:0] fallback_mode;
  int         checks = 0, fails = 0;
  bit         done = 1'b0;
  logic [7:0] rd;

  always #5 clk = ~clk;

  clkpwr_stop_ctrl u0 (.*);

  // {stop code, fast wakeup, expected pll/osc/clkout}
  localparam logic [5:0] VEC [8] = '{
    {2'b00, 1'b0, 3'b111}, {2'b00, 1'b1, 3'b111},
    {2'b01, 1'b0, 3'b110}, {2'b01, 1'b1, 3'b110},
    {2'b10, 1'b0, 3'b010}, {2'b10, 1'b1, 3'b010},
    {2'b11, 1'b0, 3'b000}, {2'b11, 1'b1, 3'b000}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_we = 1'b0;
  endtask

  task automatic rdreg(input logic a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse_stop();
    stop_req = 1'b1; step(1); stop_req = 1'b0;
  endtask

  task automatic pulse_wake();
    wake_req = 1'b1; step(1); wake_req = 1'b0;
  endtask

  function automatic logic [7:0] en4();
    return {4'b0, sysclk_en, pll_en, osc_en, clkout_en};
  endfunction

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R12 reset state
    check("R12 enables", en4(), 8'h0F);
    check("R12 fallback", {6'b0, fallback_mode}, 8'h00);
    rdreg(1'b0, rd); check("R12 ctrl", rd, 8'h00);

    // R10 two-edge lock sync, R7 status layout, R9 not yet set
    pll_lock_in = 1'b1;
    step(1); rdreg(1'b1, rd); check("R10 lock after one edge", rd, 8'hA0);
    step(1); rdreg(1'b1, rd); check("R7 status layout", rd, 8'hA8);

    // Table sweep: R1 R2 R3 R4
    for (int i = 0; i < 8; i++) begin
      logic [5:0] v;
      v = VEC[i];
      wr(1'b0, {5'b0, v[3], v[5:4]});
      pulse_stop();
      check("R1 sysclk off in stop", {7'b0, sysclk_en}, 8'h00);
      check("R2 stop enables", {5'b0, pll_en, osc_en, clkout_en}, {5'b0, v[2:0]});
      pulse_wake();
      if (v[3]) check("R3 fast wake immediate", {7'b0, sysclk_en}, 8'h01);
      else      check("R4 waits one lock cycle", {7'b0, sysclk_en}, 8'h00);
      step(1);
      check("R4 run after wake", en4(), 8'h0F);
    end

    // R11 control write while stopped
    wr(1'b0, 8'h00);
    pulse_stop();
    wr(1'b0, 8'h03);
    check("R11 enables hold", {5'b0, pll_en, osc_en, clkout_en}, 8'h07);
    pulse_wake(); step(1);

    // R8 status write inert, ctrl readback masking
    wr(1'b1, 8'hFF);
    rdreg(1'b0, rd); check("R8 ctrl after status write", rd, 8'h03);
    rdreg(1'b1, rd); check("R8 status after write", rd, 8'hA8);
    wr(1'b0, 8'hFF);
    rdreg(1'b0, rd); check("R8 ctrl mask", rd, 8'h07);

    // R5 oscillator loss -> self-clocked
    wr(1'b0, 8'h00);
    pulse_stop();
    loss_ref_in = 1'b1; step(3);
    rdreg(1'b1, rd); check("R7 loss flag", rd, 8'hAC);
    loss_ref_in = 1'b0; step(3);
    pulse_wake();
    check("R5 self-clocked", {5'b0, sysclk_en, fallback_mode}, 8'h05);
    // R5 PLL loss -> reference clock
    pulse_stop();
    check("R5 fallback cleared on stop", {6'b0, fallback_mode}, 8'h00);
    loss_pll_in = 1'b1; step(3); loss_pll_in = 1'b0; step(3);
    pulse_wake();
    check("R5 reference mode", {5'b0, sysclk_en, fallback_mode}, 8'h06);
    // R5 both lost -> oscillator wins
    pulse_stop();
    loss_ref_in = 1'b1; loss_pll_in = 1'b1; step(3);
    loss_ref_in = 1'b0; loss_pll_in = 1'b0; step(3);
    pulse_wake();
    check("R5 priority", {5'b0, sysclk_en, fallback_mode}, 8'h05);
    // R5 loss on disabled oscillator ignored
    wr(1'b0, 8'h03);
    pulse_stop();
    loss_ref_in = 1'b1; step(3); loss_ref_in = 1'b0; step(3);
    pulse_wake();
    check("R5 disabled loss ignored", {5'b0, sysclk_en, fallback_mode}, 8'h00);
    step(1);
    check("R5 normal relock path", {5'b0, sysclk_en, fallback_mode}, 8'h04);

    // R4 R9 R10 lock lost during stop
    wr(1'b0, 8'h02);
    pulse_stop();
    pll_lock_in = 1'b0; step(3);
    rdreg(1'b1, rd); check("R9 sticky set", rd, 8'hB0);
    pulse_wake();
    check("R4 no lock no clock", {7'b0, sysclk_en}, 8'h00);
    step(4);
    check("R4 still waiting", {7'b0, sysclk_en}, 8'h00);
    pll_lock_in = 1'b1;
    step(1); rdreg(1'b1, rd);
    check("R10 one edge", rd, 8'hB0);
    check("R4 before sync", {7'b0, sysclk_en}, 8'h00);
    step(1); rdreg(1'b1, rd);
    check("R9 sticky after relock", rd, 8'hB8);
    check("R4 lock seen this edge", {7'b0, sysclk_en}, 8'h00);
    step(1);
    check("R4 clock back", {7'b0, sysclk_en}, 8'h01);

    // R3 fast wake with lock low
    wr(1'b0, 8'h07);
    pulse_stop();
    pll_lock_in = 1'b0; step(3);
    pulse_wake();
    check("R3 fast wake ignores lock", {7'b0, sysclk_en}, 8'h01);

    // R6 external clock mode
    wr(1'b0, 8'h03);
    strap_pll_mode = 1'b0;
    pulse_stop();
    step(2);
    pulse_wake();
    check("R6 external immediate", {5'b0, sysclk_en, fallback_mode}, 8'h04);
    rdreg(1'b1, rd); check("R7 mode strap bit", rd & 8'h80, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule